// File: doc/BRIEF.md
# MII Transmit Nibble Serializer

This block is the MAC-side transmit path of a Media Independent Interface. A byte source hands it frames over a valid/last/ready handshake. The block turns each byte into 4-bit nibbles and drives them with a transmit enable on the transmit clock that the PHY supplies. Ahead of every frame it inserts the preamble and start-of-frame delimiter: 15 nibbles of 0x5 followed by one nibble of 0xD. After each frame it enforces a minimum idle gap.

Carrier sense and collision come from the PHY with no relation to the transmit clock, so each passes through a two-flop synchronizer. In half-duplex mode the block behaves as follows:
- While carrier is present, it waits before starting a frame.
- On a collision, it cuts the frame short and raises a one-cycle abort flag.
- It then accepts and discards the rest of the aborted frame's bytes up to the last marker.

In full-duplex mode both PHY inputs are ignored.

If the source withholds a byte in the middle of a frame, the frame ends at that point and the gap follows. The source is expected to keep bytes coming back to back.

Top module: `mii_tx_serializer`

## Requirements
- R1: During and just after reset, `mii_tx_en`, `mii_txd`, `s_ready` and `col_abort` are all 0.
- R2: `mii_tx_en` rises on the same clock edge as the first preamble nibble, 0x5. Fourteen more 0x5 nibbles follow, then one 0xD.
- R3: Payload bytes follow the 0xD directly. Each byte goes out low nibble first, with `mii_txd[0]` as the least significant bit. `mii_tx_en` stays high without a gap until the high nibble of the byte flagged last.
- R4: Whenever `mii_tx_en` is low, `mii_txd` is 0.
- R5: While a frame is being sent, `s_ready` is high only in cycles where the low nibble of a new byte is being loaded. That is the cycle right after the 0xD is presented, or right after a byte's high nibble is presented.
- R6: Between frames, `mii_tx_en` stays low for at least GAP_NIBBLES (default 24) consecutive clocks.
- R7: In half-duplex mode (`full_duplex`=0), a frame does not start while the synchronized carrier sense is high. It starts once carrier has cleared.
- R8: In half-duplex mode, `col_async` rising before clock edge N causes the following:
  - `mii_tx_en` is still high after edge N+1.
  - `mii_tx_en` is low after edge N+2 (two synchronizer stages plus one register).
  - `col_abort` is high for exactly that one cycle.
- R9: After a collision abort, the rest of the frame's bytes are accepted with `mii_tx_en` held low, up to and including the byte marked last. The next frame is then sent normally.
- R10: In full-duplex mode (`full_duplex`=1), carrier sense and collision have no effect. Frames go out complete and `col_abort` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock from the PHY |
| rst | input | 1 | Synchronous active-high reset |
| full_duplex | input | 1 | 1 = ignore carrier and collision |
| s_data | input | DATA_W | Byte from the source |
| s_valid | input | 1 | `s_data` and `s_last` are valid |
| s_last | input | 1 | Current byte ends the frame |
| s_ready | output | 1 | Byte is taken at this clock edge when `s_valid` is high |
| crs_async | input | 1 | Carrier sense, asynchronous |
| col_async | input | 1 | Collision, asynchronous |
| mii_txd | output | 4 | Transmit nibble |
| mii_tx_en | output | 1 | Transmit enable |
| col_abort | output | 1 | One-cycle pulse when a frame is aborted by collision |

## Verification
Nibbles, enable and the abort flag are registered. Each appears one edge after the state that produced it and is sampled on the falling edge that follows. For a collision, the bench raises `col_async` just after an edge and then checks in order:
- `mii_tx_en` on the falling edge after the second following rising edge, where it must still be high.
- `mii_tx_en` and `col_abort` one edge later, where the enable must be low and the flag high.
- `col_abort` again on the next edge, where it must have cleared.

The bench also checks every nibble as it appears:
- It tracks the nibble index within each frame.
- It confirms that `s_ready` coincides with an even index at or past the delimiter.
- It counts idle clocks before each rising enable, so the gap check lands on the exact cycle where a new frame begins.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;
  localparam logic [3:0] NIB_PREAMBLE = 4'h5;
  localparam logic [3:0] NIB_SFD      = 4'hD;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRE   = 3'd1,
    ST_LO    = 3'd2,
    ST_HI    = 3'd3,
    ST_FLUSH = 3'd4,
    ST_GAP   = 3'd5
  } tx_state_t;
endpackage

// File: rtl/mii_sync.sv
module mii_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d_async;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= '0;
      else     chain[g] <= chain[g-1];
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/mii_tx_fsm.sv
module mii_tx_fsm
  import mii_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PRE_NIBBLES = 15,
  parameter int GAP_NIBBLES = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              full_duplex,
  input  logic              crs_s,
  input  logic              col_s,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_valid,
  input  logic              s_last,
  output logic              s_ready,
  output logic [3:0]        txd,
  output logic              tx_en,
  output logic              abort
);
  localparam int NIBS  = DATA_W / 4;
  localparam int PRE_W = $clog2(PRE_NIBBLES + 1);
  localparam int GAP_W = $clog2(GAP_NIBBLES + 1);
  localparam int REM_W = $clog2(NIBS + 1);

  tx_state_t         st;
  logic [PRE_W-1:0]  pre_cnt;
  logic [GAP_W-1:0]  gap_cnt;
  logic [DATA_W-1:0] hold;
  logic [REM_W-1:0]  rem;
  logic              last_q;
  logic              coll_hit;
  logic              may_start;

  assign coll_hit  = !full_duplex && col_s;
  assign may_start = s_valid && (full_duplex || !crs_s);
  assign s_ready   = (st == ST_LO) || (st == ST_FLUSH);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      pre_cnt <= '0;
      gap_cnt <= '0;
      hold    <= '0;
      rem     <= '0;
      last_q  <= 1'b0;
      txd     <= 4'h0;
      tx_en   <= 1'b0;
      abort   <= 1'b0;
    end else begin
      abort <= 1'b0;
      case (st)
        ST_IDLE: begin
          tx_en <= 1'b0;
          txd   <= 4'h0;
          if (may_start) begin
            st      <= ST_PRE;
            tx_en   <= 1'b1;
            txd     <= NIB_PREAMBLE;
            pre_cnt <= PRE_W'(1);
          end
        end
        ST_PRE: begin
          if (coll_hit) begin
            tx_en <= 1'b0;
            txd   <= 4'h0;
            abort <= 1'b1;
            st    <= ST_FLUSH;
          end else if (pre_cnt == PRE_W'(PRE_NIBBLES)) begin
            txd <= NIB_SFD;
            st  <= ST_LO;
          end else begin
            txd     <= NIB_PREAMBLE;
            pre_cnt <= pre_cnt + PRE_W'(1);
          end
        end
        ST_LO: begin
          if (coll_hit) begin
            tx_en <= 1'b0;
            txd   <= 4'h0;
            abort <= 1'b1;
            if (s_valid && s_last) begin
              st      <= ST_GAP;
              gap_cnt <= GAP_W'(GAP_NIBBLES - 1);
            end else begin
              st <= ST_FLUSH;
            end
          end else if (s_valid) begin
            txd    <= s_data[3:0];
            hold   <= s_data >> 4;
            rem    <= REM_W'(NIBS - 1);
            last_q <= s_last;
            st     <= ST_HI;
          end else begin
            tx_en   <= 1'b0;
            txd     <= 4'h0;
            st      <= ST_GAP;
            gap_cnt <= GAP_W'(GAP_NIBBLES - 1);
          end
        end
        ST_HI: begin
          if (coll_hit) begin
            tx_en <= 1'b0;
            txd   <= 4'h0;
            abort <= 1'b1;
            if (last_q) begin
              st      <= ST_GAP;
              gap_cnt <= GAP_W'(GAP_NIBBLES - 1);
            end else begin
              st <= ST_FLUSH;
            end
          end else begin
            txd  <= hold[3:0];
            hold <= hold >> 4;
            rem  <= rem - REM_W'(1);
            if (rem == REM_W'(1)) begin
              if (last_q) begin
                st      <= ST_GAP;
                gap_cnt <= GAP_W'(GAP_NIBBLES - 1);
              end else begin
                st <= ST_LO;
              end
            end
          end
        end
        ST_FLUSH: begin
          tx_en <= 1'b0;
          txd   <= 4'h0;
          if (s_valid && s_last) begin
            st      <= ST_GAP;
            gap_cnt <= GAP_W'(GAP_NIBBLES - 1);
          end
        end
        ST_GAP: begin
          tx_en <= 1'b0;
          txd   <= 4'h0;
          if (gap_cnt == '0) st <= ST_IDLE;
          else               gap_cnt <= gap_cnt - GAP_W'(1);
        end
        default: begin
          st    <= ST_IDLE;
          tx_en <= 1'b0;
          txd   <= 4'h0;
        end
      endcase
    end
  end
endmodule

// File: rtl/mii_tx_serializer.sv
module mii_tx_serializer #(
  parameter int DATA_W      = 8,
  parameter int PRE_NIBBLES = 15,
  parameter int GAP_NIBBLES = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              full_duplex,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_valid,
  input  logic              s_last,
  output logic              s_ready,
  input  logic              crs_async,
  input  logic              col_async,
  output logic [3:0]        mii_txd,
  output logic              mii_tx_en,
  output logic              col_abort
);
  logic crs_s;
  logic col_s;

  mii_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async ({crs_async, col_async}),
    .q_sync  ({crs_s, col_s})
  );

  mii_tx_fsm #(
    .DATA_W      (DATA_W),
    .PRE_NIBBLES (PRE_NIBBLES),
    .GAP_NIBBLES (GAP_NIBBLES)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .full_duplex (full_duplex),
    .crs_s       (crs_s),
    .col_s       (col_s),
    .s_data      (s_data),
    .s_valid     (s_valid),
    .s_last      (s_last),
    .s_ready     (s_ready),
    .txd         (mii_txd),
    .tx_en       (mii_tx_en),
    .abort       (col_abort)
  );
endmodule

// File: rtl/mii_tx_checker.sv
module mii_tx_checker #(
  parameter int GAP_NIBBLES = 24
) (
  input logic       clk,
  input logic       rst,
  input logic       full_duplex,
  input logic       col_s,
  input logic [3:0] txd,
  input logic       tx_en,
  input logic       col_abort
);
  logic [15:0] low_run;
  logic        seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run <= '0;
      seen    <= 1'b0;
    end else begin
      if (tx_en) begin
        low_run <= '0;
        seen    <= 1'b1;
      end else if (low_run != 16'hFFFF) begin
        low_run <= low_run + 16'd1;
      end
    end
  end

  assert_idle_zero_R4: assert property (@(posedge clk) disable iff (rst)
    !tx_en |-> txd == 4'h0);

  assert_first_preamble_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_en) |-> txd == 4'h5);

  assert_gap_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(tx_en) && seen) |-> low_run >= 16'(GAP_NIBBLES));

  assert_coll_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (!full_duplex && col_s && tx_en) |=> !tx_en);

  assert_abort_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    col_abort |=> !col_abort);

  assert_abort_low_en_R8: assert property (@(posedge clk) disable iff (rst)
    col_abort |-> !tx_en);

  assert_fd_no_abort_R10: assert property (@(posedge clk) disable iff (rst)
    col_abort |-> !$past(full_duplex));
endmodule

bind mii_tx_serializer mii_tx_checker #(.GAP_NIBBLES(GAP_NIBBLES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .full_duplex (full_duplex),
  .col_s       (col_s),
  .txd         (mii_txd),
  .tx_en       (mii_tx_en),
  .col_abort   (col_abort)
);

// File: tb/mii_tx_serializer_bench.sv
module mii_tx_serializer_bench;
  localparam int GAP = 24;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       full_duplex = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic       s_valid = 1'b0;
  logic       s_last = 1'b0;
  logic       s_ready;
  logic       crs_async = 1'b0;
  logic       col_async = 1'b0;
  logic [3:0] mii_txd;
  logic       mii_tx_en;
  logic       col_abort;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mii_tx_serializer #(.GAP_NIBBLES(GAP)) u_mii_tx_serializer (
    .clk(clk), .rst(rst), .full_duplex(full_duplex),
    .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
    .crs_async(crs_async), .col_async(col_async),
    .mii_txd(mii_txd), .mii_tx_en(mii_tx_en), .col_abort(col_abort)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected stream
  byte unsigned exp_q[$];
  int           exp_len[$];

  function automatic int frame_nibbles(input int len);
    return 16 + 2 * len;
  endfunction

  // monitor
  bit         mon_on = 1'b1;
  int         nib = 0;
  int         low_cnt = 0;
  bit         prev_en = 1'b0;
  bit         seen = 1'b0;
  logic [3:0] lo_nib = 4'h0;

  always @(negedge clk) begin
    if (!rst) begin
      if (mii_tx_en) begin
        if (mon_on) begin
          if (nib < 15) chk(mii_txd == 4'h5, "R2 preamble", mii_txd, 5);
          else if (nib == 15) chk(mii_txd == 4'hD, "R2 sfd", mii_txd, 13);
          else if (nib % 2 == 0) lo_nib = mii_txd;
          else begin
            if (exp_q.size() == 0) chk(1'b0, "R3 extra byte", {mii_txd, lo_nib}, -1);
            else begin
              byte unsigned e;
              e = exp_q.pop_front();
              chk({mii_txd, lo_nib} == e, "R3 byte", {mii_txd, lo_nib}, e);
            end
          end
          if (!prev_en && seen) chk(low_cnt >= GAP, "R6 gap", low_cnt, GAP);
        end
        nib++;
        low_cnt = 0;
        seen = 1'b1;
      end else begin
        if (mon_on) begin
          chk(mii_txd == 4'h0, "R4 idle data", mii_txd, 0);
          if (prev_en) begin
            int el;
            el = (exp_len.size() > 0) ? exp_len.pop_front() : -1;
            chk(nib == frame_nibbles(el), "R3 frame length", nib, frame_nibbles(el));
          end
        end
        nib = 0;
        low_cnt++;
      end
      if (mon_on && s_ready)
        chk(mii_tx_en && nib >= 16 && nib % 2 == 0, "R5 ready position", nib, 16);
      prev_en = mii_tx_en;
    end
  end

  task automatic send_frame(input int len, input bit push);
    byte unsigned b;
    if (push) exp_len.push_back(len);
    for (int i = 0; i < len; i++) begin
      b = 8'($urandom);
      if (push) exp_q.push_back(b);
      s_data  = b;
      s_valid = 1'b1;
      s_last  = (i == len - 1);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
    end
    s_valid = 1'b0;
    s_last  = 1'b0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0 || mii_tx_en) @(negedge clk);
    repeat (GAP + 4) @(negedge clk);
  endtask

  initial begin
    bit ok_flag;
    bit drv_done;
    int seed;
    seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    chk(mii_tx_en == 0 && mii_txd == 0 && s_ready == 0 && col_abort == 0, "R1 in reset",
        {mii_tx_en, mii_txd, s_ready, col_abort}, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(mii_tx_en == 0 && mii_txd == 0 && s_ready == 0 && col_abort == 0, "R1 after reset",
        {mii_tx_en, mii_txd, s_ready, col_abort}, 0);

    // directed: single byte frame and back-to-back frames (R2 R3 R5 R6)
    send_frame(1, 1'b1);
    send_frame(3, 1'b1);
    wait_idle();

    // random frames, mixed duplex
    for (int f = 0; f < 30; f++) begin
      full_duplex = 1'($urandom);
      send_frame(int'($urandom_range(1, 20)), 1'b1);
      repeat ($urandom_range(0, 5)) @(negedge clk);
    end
    wait_idle();

    // R7: deferral on carrier in half duplex
    full_duplex = 1'b0;
    crs_async = 1'b1;
    repeat (3) @(negedge clk);
    ok_flag = 1'b1;
    fork
      send_frame(4, 1'b1);
      begin
        repeat (20) begin
          @(negedge clk);
          if (mii_tx_en || s_ready) ok_flag = 1'b0;
        end
        chk(ok_flag, "R7 held off by carrier", ok_flag, 1);
        crs_async = 1'b0;
      end
    join
    wait_idle();

    // R10: full duplex ignores carrier and collision
    full_duplex = 1'b1;
    crs_async = 1'b1;
    col_async = 1'b1;
    ok_flag = 1'b1;
    fork
      send_frame(6, 1'b1);
      begin
        repeat (40) begin
          @(negedge clk);
          if (col_abort) ok_flag = 1'b0;
        end
      end
    join
    wait_idle();
    chk(ok_flag, "R10 no abort in full duplex", ok_flag, 1);
    chk(exp_q.size() == 0, "R10 frame complete", exp_q.size(), 0);
    crs_async = 1'b0;
    col_async = 1'b0;
    full_duplex = 1'b0;
    repeat (4) @(negedge clk);

    // R8 / R9: collision abort and flush in half duplex
    mon_on = 1'b0;
    drv_done = 1'b0;
    fork
      begin
        send_frame(20, 1'b0);
        drv_done = 1'b1;
      end
      begin
        while (nib < 30) @(posedge clk);
        #1 col_async = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk(mii_tx_en == 1'b1, "R8 enable still high", mii_tx_en, 1);
        @(posedge clk);
        @(negedge clk);
        chk(mii_tx_en == 1'b0, "R8 enable dropped", mii_tx_en, 0);
        chk(col_abort == 1'b1, "R8 abort flag", col_abort, 1);
        @(negedge clk);
        chk(col_abort == 1'b0, "R8 abort one cycle", col_abort, 0);
        col_async = 1'b0;
        ok_flag = 1'b1;
        while (!drv_done) begin
          if (mii_tx_en) ok_flag = 1'b0;
          @(negedge clk);
        end
        chk(ok_flag, "R9 flush keeps enable low", ok_flag, 1);
      end
    join
    repeat (GAP + 6) @(negedge clk);
    chk(mii_tx_en == 1'b0, "R9 idle after flush", mii_tx_en, 0);
    mon_on = 1'b1;
    send_frame(5, 1'b1);
    wait_idle();
    chk(exp_q.size() == 0 && exp_len.size() == 0, "R9 next frame sent", exp_q.size(), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule